// File: doc/BRIEF.md
# Lane-Interleaved Vector Adder

This unit holds a bank of vector registers and, on command, adds two of them element by element into a third. The storage is split across four lanes. Element `i` of every register lives in lane `i mod 4`, at row `i div 4` inside that lane. Each lane owns a pipelined adder that reads its two operands from its own slice of the bank and writes the sum back into the same slice. One group of four adjacent elements is issued per clock, so an operation of length `n` takes `ceil(n/4)` issue cycles plus the adder latency.

An operation starts with a one-cycle `start` pulse. The pulse carries the two source indices, the destination index and the vector length. `busy` stays high until the last sum has been written, and `done` then pulses for one cycle. The unit has no streaming interface and no back-pressure. `start` is taken only while `busy` is low, and any other pulse is dropped. A plain element port loads and reads registers. Its write side is taken only while the unit is idle. Its read side is combinational.

Top module: `vadd_unit`

## Requirements
- R1: For every element index `i` below the effective length, the destination element `i` becomes `(srcA[i] + srcB[i]) mod 2^16`.
- R2: Destination elements at index equal to or above the effective length keep their previous value. When the length is not a multiple of four, the lanes past the end of the last group do not write.
- R3: Busy lasts exactly `ceil(L/4) + 3` cycles for effective length `L`, with the default adder depth of 3. Four elements retire per cycle.
- R4: `busy` rises in the cycle after an accepted `start`. `done` is high for exactly one cycle, in the cycle where `busy` has just fallen.
- R5: A `start` pulse that arrives while `busy` is high is ignored. It neither changes the running operation's timing nor writes its own destination.
- R6: An element write on the load port while `busy` is high is ignored, and the addressed element keeps its value.
- R7: A length above 16 is treated as 16. A length of 0 writes nothing and keeps `busy` high for 3 cycles.
- R8: The destination may equal a source. Each sum uses the source values from before the operation.
- R9: After reset, `busy` and `done` are low and every element of every register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle operation request |
| src_a | input | 4 | First source register index |
| src_b | input | 4 | Second source register index |
| dst | input | 4 | Destination register index |
| vlen | input | 5 | Requested vector length (values above 16 are clamped) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_en | input | 1 | Element load strobe (ignored while busy) |
| wr_reg | input | 4 | Register index for load |
| wr_idx | input | 4 | Element index for load |
| wr_data | input | 16 | Element value for load |
| rd_reg | input | 4 | Register index for read |
| rd_idx | input | 4 | Element index for read |
| rd_data | output | 16 | Element value read (combinational) |

## Verification
Operations are run with a full length of 16, lengths of 5 and 3 that leave a partial final group, a length of 0 and a clamped length of 20. The partial lengths show whether the tail lanes are masked correctly. The zero and clamped lengths probe both ends of the length decode. An in-place run, where the destination equals a source, separates correct read-before-write ordering from a design that reads back its own fresh sums. Operand values near the top of the 16-bit range check the wrap-around. A `start` and a load-port write injected mid-operation confirm that neither disturbs the running work. The bench predicts `busy` and `done` for every cycle of every operation, and after each operation it scans the whole register bank against a behavioural model.

// File: rtl/vadd_pkg.sv
package vadd_pkg;
  function automatic int ceil_div(input int n, input int d);
    return (n + d - 1) / d;
  endfunction
endpackage

// File: rtl/vadd_lane_rf.sv
module vadd_lane_rf #(
  parameter int W     = 16,
  parameter int WORDS = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [W-1:0]  ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [W-1:0]  rb_data,
  input  logic [AW-1:0] rx_addr,
  output logic [W-1:0]  rx_data
);
  logic [W-1:0] mem_q [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign ra_data = mem_q[ra_addr];
  assign rb_data = mem_q[rb_addr];
  assign rx_data = mem_q[rx_addr];
endmodule

// File: rtl/vadd_lane_pipe.sv
module vadd_lane_pipe #(
  parameter int W    = 16,
  parameter int AW   = 6,
  parameter int PIPE = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_v,
  input  logic [AW-1:0] in_addr,
  input  logic [W-1:0]  in_a,
  input  logic [W-1:0]  in_b,
  output logic          out_v,
  output logic [AW-1:0] out_addr,
  output logic [W-1:0]  out_sum
);
  logic          stg_v    [PIPE];
  logic [AW-1:0] stg_addr [PIPE];
  logic [W-1:0]  stg_sum  [PIPE];

  always_ff @(posedge clk) begin
    if (!rst_n) stg_v[0] <= 1'b0;
    else        stg_v[0] <= in_v;
    stg_addr[0] <= in_addr;
    stg_sum[0]  <= in_a + in_b;
  end

  for (genvar s = 1; s < PIPE; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg_v[s] <= 1'b0;
      else        stg_v[s] <= stg_v[s-1];
      stg_addr[s] <= stg_addr[s-1];
      stg_sum[s]  <= stg_sum[s-1];
    end
  end

  assign out_v    = stg_v[PIPE-1];
  assign out_addr = stg_addr[PIPE-1];
  assign out_sum  = stg_sum[PIPE-1];
endmodule

// File: rtl/vadd_seq.sv
module vadd_seq
  import vadd_pkg::*;
#(
  parameter int LANES = 4,
  parameter int MAXVL = 16,
  parameter int NREG  = 16,
  parameter int PIPE  = 3,
  localparam int DEPTH = MAXVL / LANES,
  localparam int GW    = $clog2(DEPTH),
  localparam int RW    = $clog2(NREG),
  localparam int VLW   = $clog2(MAXVL + 1),
  localparam int CW    = $clog2(DEPTH + PIPE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [RW-1:0]    src_a,
  input  logic [RW-1:0]    src_b,
  input  logic [RW-1:0]    dst,
  input  logic [VLW-1:0]   vlen,
  output logic             busy,
  output logic             done,
  output logic [LANES-1:0] issue_v,
  output logic [GW-1:0]    issue_row,
  output logic [RW-1:0]    ra_q,
  output logic [RW-1:0]    rb_q,
  output logic [RW-1:0]    rd_q
);
  logic [CW-1:0]  remain_q;
  logic [GW:0]    grp_q;
  logic [VLW-1:0] vl_q;
  logic [VLW-1:0] vl_eff;
  logic [CW-1:0]  ngrp;
  logic           done_q;

  assign vl_eff = (int'(vlen) > MAXVL) ? VLW'(MAXVL) : vlen;
  assign ngrp   = CW'(ceil_div(int'(vl_eff), LANES));
  assign busy   = (remain_q != '0);
  assign done   = done_q;
  assign issue_row = grp_q[GW-1:0];

  for (genvar k = 0; k < LANES; k++) begin : g_issue
    assign issue_v[k] = busy && ((int'(grp_q) * LANES + k) < int'(vl_q));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q <= '0;
      grp_q    <= '0;
      vl_q     <= '0;
      ra_q     <= '0;
      rb_q     <= '0;
      rd_q     <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy) begin
        remain_q <= ngrp + CW'(PIPE);
        grp_q    <= '0;
        vl_q     <= vl_eff;
        ra_q     <= src_a;
        rb_q     <= src_b;
        rd_q     <= dst;
      end else if (busy) begin
        remain_q <= remain_q - 1'b1;
        if (|issue_v) grp_q <= grp_q + 1'b1;
        done_q <= (remain_q == CW'(1));
      end
    end
  end

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(rd_q) && $stable(vl_q))); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R4
  AST_LEN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(vl_q) <= MAXVL)); // R7
  for (genvar k = 0; k < LANES - 1; k++) begin : g_tail_chk
    AST_TAIL_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
      issue_v[k+1] |-> issue_v[k]); // R2
  end
endmodule

// File: rtl/vadd_unit.sv
module vadd_unit #(
  parameter int W     = 16,
  parameter int LANES = 4,
  parameter int MAXVL = 16,
  parameter int NREG  = 16,
  parameter int PIPE  = 3,
  localparam int DEPTH = MAXVL / LANES,
  localparam int GW    = $clog2(DEPTH),
  localparam int LB    = $clog2(LANES),
  localparam int RW    = $clog2(NREG),
  localparam int IW    = $clog2(MAXVL),
  localparam int VLW   = $clog2(MAXVL + 1),
  localparam int AW    = RW + GW,
  localparam int WORDS = NREG * DEPTH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [RW-1:0]  src_a,
  input  logic [RW-1:0]  src_b,
  input  logic [RW-1:0]  dst,
  input  logic [VLW-1:0] vlen,
  output logic           busy,
  output logic           done,
  input  logic           wr_en,
  input  logic [RW-1:0]  wr_reg,
  input  logic [IW-1:0]  wr_idx,
  input  logic [W-1:0]   wr_data,
  input  logic [RW-1:0]  rd_reg,
  input  logic [IW-1:0]  rd_idx,
  output logic [W-1:0]   rd_data
);
  logic [LANES-1:0] issue_v;
  logic [GW-1:0]    issue_row;
  logic [RW-1:0]    ra_q, rb_q, rd_q;

  logic [LANES-1:0] pipe_v;
  logic [AW-1:0]    pipe_addr [LANES];
  logic [W-1:0]     pipe_sum  [LANES];
  logic [W-1:0]     rx_data   [LANES];

  logic [LB-1:0]    wr_lane, rd_lane;
  logic [GW-1:0]    wr_row, rd_row;

  assign wr_lane = wr_idx[LB-1:0];
  assign wr_row  = wr_idx[IW-1:LB];
  assign rd_lane = rd_idx[LB-1:0];
  assign rd_row  = rd_idx[IW-1:LB];

  vadd_seq #(
    .LANES(LANES), .MAXVL(MAXVL), .NREG(NREG), .PIPE(PIPE)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_a(src_a), .src_b(src_b), .dst(dst), .vlen(vlen),
    .busy(busy), .done(done),
    .issue_v(issue_v), .issue_row(issue_row),
    .ra_q(ra_q), .rb_q(rb_q), .rd_q(rd_q)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic          we;
    logic [AW-1:0] waddr;
    logic [W-1:0]  wdata;
    logic [W-1:0]  opa, opb;

    always_comb begin
      if (pipe_v[k]) begin
        we    = 1'b1;
        waddr = pipe_addr[k];
        wdata = pipe_sum[k];
      end else begin
        we    = wr_en && !busy && (wr_lane == LB'(k));
        waddr = {wr_reg, wr_row};
        wdata = wr_data;
      end
    end

    vadd_lane_rf #(.W(W), .WORDS(WORDS), .AW(AW)) rf_i (
      .clk(clk), .rst_n(rst_n),
      .we(we), .waddr(waddr), .wdata(wdata),
      .ra_addr({ra_q, issue_row}), .ra_data(opa),
      .rb_addr({rb_q, issue_row}), .rb_data(opb),
      .rx_addr({rd_reg, rd_row}),  .rx_data(rx_data[k])
    );

    vadd_lane_pipe #(.W(W), .AW(AW), .PIPE(PIPE)) pipe_i (
      .clk(clk), .rst_n(rst_n),
      .in_v(issue_v[k]), .in_addr({rd_q, issue_row}),
      .in_a(opa), .in_b(opb),
      .out_v(pipe_v[k]), .out_addr(pipe_addr[k]), .out_sum(pipe_sum[k])
    );

    AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      pipe_v[k] |-> busy); // R6
  end

  assign rd_data = rx_data[rd_lane];
endmodule

// File: tb/vadd_unit_tb.sv
module vadd_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 16;
  localparam int NE = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  src_a = '0, src_b = '0, dst = '0;
  logic [4:0]  vlen = '0;
  logic        busy, done;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_reg = '0, wr_idx = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  rd_reg = '0, rd_idx = '0;
  logic [15:0] rd_data;

  int model [NR][NE];
  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vadd_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_a(src_a), .src_b(src_b), .dst(dst), .vlen(vlen),
    .busy(busy), .done(done),
    .wr_en(wr_en), .wr_reg(wr_reg), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_reg(rd_reg), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic poke(input int r, input int i, input int v);
    @(negedge clk);
    wr_en = 1'b1; wr_reg = 4'(r); wr_idx = 4'(i); wr_data = 16'(v);
    model[r][i] = v & 16'hFFFF;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic scan_all(input string req);
    for (int r = 0; r < NR; r++) begin
      for (int i = 0; i < NE; i++) begin
        @(negedge clk);
        rd_reg = 4'(r); rd_idx = 4'(i);
        #1;
        chk(int'(rd_data) == model[r][i], req, int'(rd_data), model[r][i]);
      end
    end
  endtask

  // Runs one operation and checks busy/done on every cycle against the model.
  task automatic run_op(input int a, input int b, input int d, input int vl,
                        input bit inject, input string req);
    int len, t;
    int na [NE];
    len = (vl > NE) ? NE : vl;
    t = (len + 3) / 4 + 3;
    for (int i = 0; i < NE; i++) na[i] = model[d][i];
    for (int i = 0; i < len; i++) na[i] = (model[a][i] + model[b][i]) & 16'hFFFF;
    for (int i = 0; i < NE; i++) model[d][i] = na[i];
    @(negedge clk);
    start = 1'b1; src_a = 4'(a); src_b = 4'(b); dst = 4'(d); vlen = 5'(vl);
    for (int k = 1; k <= t + 2; k++) begin
      @(negedge clk);
      if (k == 1) start = 1'b0;
      if (inject && k == 2) begin
        // R5 / R6: a second start and a load write while busy
        start = 1'b1; src_a = 4'(a); src_b = 4'(b); dst = 4'd6; vlen = 5'd16;
        wr_en = 1'b1; wr_reg = 4'd7; wr_idx = 4'd0; wr_data = 16'h1234;
      end
      if (inject && k == 3) begin
        start = 1'b0; wr_en = 1'b0;
      end
      #1;
      chk(busy == (k <= t), {req, " busy (R3/R4)"}, int'(busy), int'(k <= t));
      chk(done == (k == t + 1), {req, " done (R4)"}, int'(done), int'(k == t + 1));
    end
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000 && !finished) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 100000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    for (int r = 0; r < NR; r++)
      for (int i = 0; i < NE; i++) model[r][i] = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(busy == 1'b0, "R9 busy at reset", int'(busy), 0);
    chk(done == 1'b0, "R9 done at reset", int'(done), 0);
    rst_n = 1'b1;
    scan_all("R9 reset contents");

    // Operands, some close to the top of the range for wrap-around (R1)
    for (int i = 0; i < NE; i++) begin
      poke(1, i, (i * 4099 + 65000) & 16'hFFFF);
      poke(2, i, (i * 771 + 300) & 16'hFFFF);
      poke(3, i, 16'hA5A5);
      poke(4, i, 16'h5A00 + i);
      poke(5, i, 16'h0F0F);
      poke(7, i, 16'h7700 + i);
    end
    scan_all("R6 load port idle");

    run_op(1, 2, 3, 16, 1'b0, "R1 full length");
    scan_all("R1 full length contents");
    run_op(2, 1, 4, 5, 1'b0, "R2 length 5");
    scan_all("R2 length 5 contents");
    run_op(1, 1, 5, 3, 1'b0, "R2 length 3");
    scan_all("R2 length 3 contents");
    run_op(1, 2, 4, 0, 1'b0, "R7 length 0");
    scan_all("R7 length 0 contents");
    run_op(2, 2, 8, 20, 1'b0, "R7 clamp 20");
    scan_all("R7 clamp contents");
    run_op(1, 2, 1, 9, 1'b0, "R8 in place");
    scan_all("R8 in place contents");
    run_op(3, 4, 5, 16, 1'b1, "R5 R6 inject");
    scan_all("R5 R6 inject contents");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule